// File: doc/BRIEF.md
# Link Port Interrupt Collector

This block gathers the interrupt sources of one link port and drives a single interrupt line upstream. Software reaches it through four word registers: a status word, a mask word, and two mask aliases. A one written to the set alias masks a source. A one written to the clear alias unmasks it. The mask word itself cannot be written, so updating the mask never needs a read-modify-write.

The four lowest sources are level-sensitive legacy lines. Their status bits mirror the input pins and software cannot clear them. Every other source is an edge event, such as link up, link down, completion timeout or a message-signalled interrupt fault. An edge event latches in the status word when the source rises, and software clears it by writing a one to that bit. Driver start-up writes all ones to the set alias and then all ones to the status word. After that, every source is masked and nothing is latched.

The source bit positions are fixed: port error and the error-reporting group 4..7, bandwidth notice 11, link up 12, link down 14, fabric timeout 15, wide-address request 17, message-interrupt error 18, message-interrupt bad data 19, completion abort 21, ID-map fault 22, completion timeout 23, tunnel fault 31. The block treats every bit at position 4 or above in the same way.

Top module: `port_irq_agg`

## Requirements
- R1: On reset release the mask reads all ones and every edge status bit (4..31) reads zero. With all sources low, `irq_o` is low.
- R2: Status bits 0..3 always equal `src_i[3:0]` in the same cycle. Writing ones to them at offset 0x100 has no effect.
- R3: For bits 4..31, a source that is low at one rising clock edge and high at the next sets its status bit at that second edge. The bit stays set after the source falls.
- R4: A write to offset 0x100 clears each edge status bit whose write-data bit is one. Bits written as zero keep their value.
- R5: A write to offset 0x108 sets each mask bit whose write-data bit is one. Zero bits leave the mask unchanged.
- R6: A write to offset 0x10C clears each mask bit whose write-data bit is one. Zero bits leave the mask unchanged.
- R7: `irq_o` is high exactly when some bit of (status AND NOT mask) is one.
- R8: If an edge bit rises in the same cycle that offset 0x100 is written with a one in that bit, the bit ends up set.
- R9: Reading 0x100 returns the status. Reading 0x104, 0x108 or 0x10C returns the current mask. Any other address reads zero.
- R10: Writes to 0x104, to unmapped addresses or to addresses whose low two bits are non-zero change neither the mask nor the status.
- R11: Writing all ones to 0x108 and then all ones to 0x100 leaves the mask at all ones, every edge bit at zero and `irq_o` low, provided the legacy lines are low.
- R12: Clearing an edge bit while its source stays high leaves the bit clear until the source falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Interrupt sources; bits 0..3 are level lines, the rest are edge events |
| wr_en | input | 1 | Register write strobe, applied at the rising edge |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Upstream interrupt, high while any unmasked status bit is set |

## Verification
The bench raises a source in the same cycle as a write-one-to-clear of that bit. A design that lets the clear win would silently drop a link event. It clears a bit while its source stays high. A design that latches on level instead of on a rise would set the bit again at once and keep interrupting. It writes ones to the legacy bits, to the mask word and to unaligned and unmapped addresses. A decoder that is too loose would make the legacy lines look cleared or would corrupt the mask. It also checks that zero bits in the set and clear aliases leave the mask alone, which a read-modify-write design could get wrong.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;

    // Word slot within the register window; the order is the address order.
    typedef enum logic [1:0] {
        SLOT_STAT = 2'd0,
        SLOT_MASK = 2'd1,
        SLOT_MSET = 2'd2,
        SLOT_MCLR = 2'd3
    } slot_e;

    typedef struct packed {
        logic  hit;      // address falls on one of the four words
        slot_e slot;     // which word
        logic  stat_w1c; // write strobe: clear latched status bits
        logic  mset;     // write strobe: set mask bits
        logic  mclr;     // write strobe: clear mask bits
    } dec_t;

endpackage

// File: rtl/port_irq_decode.sv
module port_irq_decode
    import port_irq_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] BASE_OFF = 12'h100
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int              WORD_W    = ADDR_W - 2;
    localparam logic [WORD_W-1:0] BASE_WORD = BASE_OFF[ADDR_W-1:2];
    localparam logic [WORD_W-1:0] N_WORDS   = WORD_W'(4);

    logic [WORD_W-1:0] word_rel;

    always_comb begin
        dec      = '0;
        word_rel = addr[ADDR_W-1:2] - BASE_WORD;
        if ((addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] >= BASE_WORD)
            && (word_rel < N_WORDS)) begin
            dec.hit      = 1'b1;
            dec.slot     = slot_e'(word_rel[1:0]);
            dec.stat_w1c = wr_en && (dec.slot == SLOT_STAT);
            dec.mset     = wr_en && (dec.slot == SLOT_MSET);
            dec.mclr     = wr_en && (dec.slot == SLOT_MCLR);
        end
    end

endmodule

// File: rtl/port_irq_mask.sv
module port_irq_mask #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mstate_t;

    mstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_stb) st_d.mask = st_d.mask | wdata;
        if (clr_stb) st_d.mask = st_d.mask & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mask: '1};
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;

endmodule

// File: rtl/port_irq_status.sv
module port_irq_status #(
    parameter int W         = 32,
    parameter int NUM_LEVEL = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat_o
);
    localparam logic [W-1:0] EDGE_MASK =
        {{(W-NUM_LEVEL){1'b1}}, {NUM_LEVEL{1'b0}}};

    typedef struct packed {
        logic [W-1:0] prev; // source value at the previous edge
        logic [W-1:0] lat;  // latched edge events
    } sstate_t;

    sstate_t      st_d, st_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr_bits;

    always_comb begin
        st_d     = st_q;
        rise     = src_i & ~st_q.prev & EDGE_MASK;
        clr_bits = clr_stb ? wdata : '0;
        st_d.prev = src_i;
        // A new rise outranks a clear issued in the same cycle.
        st_d.lat  = ((st_q.lat & ~clr_bits) | rise) & EDGE_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < NUM_LEVEL) begin : g_level
            assign stat_o[i] = src_i[i];
        end else begin : g_edge
            assign stat_o[i] = st_q.lat[i];
        end
    end

endmodule

// File: rtl/port_irq_agg.sv
module port_irq_agg
    import port_irq_pkg::*;
#(
    parameter int                NUM_SRC   = 32,
    parameter int                NUM_LEVEL = 4,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_OFF  = 12'h100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] rdata,
    output logic               irq_o
);
    dec_t               dec;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] stat_vec;

    port_irq_decode #(.ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .dec   (dec)
    );

    port_irq_mask #(.W(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (dec.mset),
        .clr_stb (dec.mclr),
        .wdata   (wdata),
        .mask_o  (mask_q)
    );

    port_irq_status #(.W(NUM_SRC), .NUM_LEVEL(NUM_LEVEL)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .clr_stb (dec.stat_w1c),
        .wdata   (wdata),
        .stat_o  (stat_vec)
    );

    always_comb begin
        rdata = '0;
        if (dec.hit) begin
            if (dec.slot == SLOT_STAT) rdata = stat_vec;
            else                       rdata = mask_q;
        end
    end

    assign irq_o = |(stat_vec & ~mask_q);

endmodule

// File: rtl/port_irq_agg_chk.sv
module port_irq_agg_chk #(
    parameter int                NUM_SRC   = 32,
    parameter int                NUM_LEVEL = 4,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_OFF  = 12'h100
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [NUM_SRC-1:0] wdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] mask,
    input logic [NUM_SRC-1:0] stat
);
    localparam logic [ADDR_W-1:0] A_STAT = BASE_OFF;
    localparam logic [ADDR_W-1:0] A_MSET = BASE_OFF + ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_MCLR = BASE_OFF + ADDR_W'(12);
    localparam logic [NUM_SRC-1:0] EDGE_MASK =
        {{(NUM_SRC-NUM_LEVEL){1'b1}}, {NUM_LEVEL{1'b0}}};

    logic [NUM_SRC-1:0] prev_c;
    logic [NUM_SRC-1:0] rise_c;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_c <= '0;
        else        prev_c <= src_i;
    end

    assign rise_c = src_i & ~prev_c & EDGE_MASK;

    p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MSET) |=> ((mask & $past(wdata)) == $past(wdata)));

    p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MCLR) |=> ((mask & $past(wdata)) == '0));

    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == A_MSET || addr == A_MCLR)) |=> $stable(mask));

    p_edge_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_c != '0) |=> ((stat & $past(rise_c)) == $past(rise_c)));

    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STAT && (rise_c & wdata) != '0)
        |=> ((stat & $past(rise_c & wdata)) == $past(rise_c & wdata)));

    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STAT)
        |=> ((stat & $past(wdata & ~rise_c & EDGE_MASK)) == '0));

    p_level_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_i & ~mask & ~EDGE_MASK) != '0) |-> irq_o);

endmodule

bind port_irq_agg port_irq_agg_chk #(
    .NUM_SRC   (NUM_SRC),
    .NUM_LEVEL (NUM_LEVEL),
    .ADDR_W    (ADDR_W),
    .BASE_OFF  (BASE_OFF)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .irq_o (irq_o),
    .mask  (mask_q),
    .stat  (stat_vec)
);

// File: tb/sim_port_irq_agg.sv
`timescale 1ns/1ps
module sim_port_irq_agg;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    port_irq_agg u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #2 v = rdata;
    endtask

    task automatic peek_irq(output logic v);
        @(negedge clk);
        #2 v = irq_o;
    endtask

    task automatic drive_src(input logic [31:0] v);
        @(negedge clk);
        src_i = v;
    endtask

    task automatic t_reset();
        logic [31:0] v; logic q;
        bus_rd(12'h104, v); chk("R1 mask after reset", v, 32'hFFFF_FFFF);
        bus_rd(12'h100, v); chk("R1 status after reset", v, 32'h0);
        peek_irq(q);        chk("R1 irq after reset", {31'b0, q}, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v; logic q;
        drive_src(32'h5);
        bus_rd(12'h100, v); chk("R2 level bits follow lines", v, 32'h5);
        bus_wr(12'h100, 32'hF);
        bus_rd(12'h100, v); chk("R2 level bits not clearable", v, 32'h5);
        peek_irq(q);        chk("R7 masked level gives no irq", {31'b0, q}, 32'h0);
        bus_wr(12'h10C, 32'h1);
        bus_rd(12'h104, v); chk("R6 clear alias unmasks bit 0", v, 32'hFFFF_FFFE);
        peek_irq(q);        chk("R7 unmasked level raises irq", {31'b0, q}, 32'h1);
        drive_src(32'h4);
        peek_irq(q);        chk("R7 irq drops with line, other bit masked", {31'b0, q}, 32'h0);
        drive_src(32'h0);
        bus_wr(12'h108, 32'h1);
        bus_rd(12'h104, v); chk("R5 set alias masks bit 0", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_edge();
        logic [31:0] v; logic q;
        drive_src(32'h0000_1000);
        drive_src(32'h0);
        bus_rd(12'h100, v); chk("R3 link-up bit latched after source falls", v, 32'h0000_1000);
        peek_irq(q);        chk("R7 latched but masked", {31'b0, q}, 32'h0);
        bus_wr(12'h10C, 32'h0000_1000);
        peek_irq(q);        chk("R7 latched and unmasked", {31'b0, q}, 32'h1);
        bus_wr(12'h100, 32'h0);
        bus_rd(12'h100, v); chk("R4 zero write keeps bit", v, 32'h0000_1000);
        bus_wr(12'h100, 32'hFFFF_EFFF);
        bus_rd(12'h100, v); chk("R4 other ones keep bit", v, 32'h0000_1000);
        bus_wr(12'h100, 32'h0000_1000);
        bus_rd(12'h100, v); chk("R4 one clears bit", v, 32'h0);
        peek_irq(q);        chk("R7 irq drops after clear", {31'b0, q}, 32'h0);
        drive_src(32'h0000_1000);
        bus_rd(12'h100, v); chk("R3 second rise latches", v, 32'h0000_1000);
        bus_wr(12'h100, 32'h0000_1000);
        bus_rd(12'h100, v); chk("R12 held source stays clear", v, 32'h0);
        bus_rd(12'h100, v); chk("R12 still clear later", v, 32'h0);
        drive_src(32'h0);
        bus_wr(12'h108, 32'h0000_1000);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        drive_src(32'h0080_4000);
        drive_src(32'h0);
        bus_rd(12'h100, v); chk("R3 two edge bits latched", v, 32'h0080_4000);
        @(negedge clk);
        src_i = 32'h0000_4000; wr_en = 1'b1; addr = 12'h100; wdata = 32'h0080_4000;
        @(negedge clk);
        src_i = 32'h0; wr_en = 1'b0; wdata = '0;
        bus_rd(12'h100, v); chk("R8 rise beats same-cycle clear", v, 32'h0000_4000);
        bus_wr(12'h100, 32'h0000_4000);
        bus_rd(12'h100, v); chk("R4 cleanup", v, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        bus_wr(12'h10C, 32'h0000_F000);
        bus_rd(12'h104, v); chk("R6 clear alias nibble", v, 32'hFFFF_0FFF);
        bus_wr(12'h104, 32'h0);
        bus_rd(12'h104, v); chk("R10 mask word not writable", v, 32'hFFFF_0FFF);
        bus_wr(12'h108, 32'h0);
        bus_rd(12'h104, v); chk("R5 zero set write no effect", v, 32'hFFFF_0FFF);
        bus_wr(12'h10C, 32'h0);
        bus_rd(12'h104, v); chk("R6 zero clear write no effect", v, 32'hFFFF_0FFF);
        bus_rd(12'h108, v); chk("R9 set alias reads mask", v, 32'hFFFF_0FFF);
        bus_rd(12'h10C, v); chk("R9 clear alias reads mask", v, 32'hFFFF_0FFF);
        bus_rd(12'h110, v); chk("R9 unmapped reads zero", v, 32'h0);
        bus_rd(12'h0FC, v); chk("R9 below window reads zero", v, 32'h0);
        bus_wr(12'h10D, 32'hFFFF_FFFF);
        bus_rd(12'h104, v); chk("R10 unaligned write ignored", v, 32'hFFFF_0FFF);
        bus_wr(12'h00C, 32'hFFFF_FFFF);
        bus_rd(12'h104, v); chk("R10 unmapped write ignored", v, 32'hFFFF_0FFF);
        drive_src(32'h0000_8000);
        drive_src(32'h0);
        bus_wr(12'h101, 32'h0000_8000);
        bus_rd(12'h100, v); chk("R10 unaligned status write ignored", v, 32'h0000_8000);
        bus_wr(12'h100, 32'h0000_8000);
        bus_wr(12'h108, 32'h0000_F000);
    endtask

    task automatic t_init();
        logic [31:0] v; logic q;
        drive_src(32'h8002_0000);
        drive_src(32'h0);
        bus_wr(12'h10C, 32'hFFFF_FFFF);
        peek_irq(q);        chk("R7 irq with all unmasked", {31'b0, q}, 32'h1);
        bus_wr(12'h108, 32'hFFFF_FFFF);
        bus_wr(12'h100, 32'hFFFF_FFFF);
        bus_rd(12'h104, v); chk("R11 init leaves all masked", v, 32'hFFFF_FFFF);
        bus_rd(12'h100, v); chk("R11 init clears edge bits", v, 32'h0);
        peek_irq(q);        chk("R11 init leaves irq low", {31'b0, q}, 32'h0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_level();
        t_edge();
        t_collision();
        t_regmap();
        t_init();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule